// File: doc/BRIEF.md
# Serial Audio Transmit Engine

This block turns 32-bit sample words written by a bus master into a two-slot serial audio stream. A small register file holds the word format, the frame length, the bit-clock ratio, the request threshold and the run and clear controls. Sample words are written to a data address and enter a 32-entry transmit FIFO. A serializer drains the FIFO one word per slot. It drives the serial data line and a slot-select line, both timed by a bit clock divided down from the block clock.

The frame is split into two slots. Slot-select is high for the first slot and low for the second. Within a slot, the valid bits can sit one bit after the slot edge (the classic delayed format), flush at the start of the slot, or flush at its end, and they go out MSB- or LSB-first. A request line asks an external DMA engine for more data while the FIFO is at or below a programmable level. When the FIFO runs dry, the serializer repeats the last word and raises a sticky underflow flag. A self-clearing clear command flushes the FIFO and returns the serial side to its idle state.

Top module: `aud_tx_top`

## Requirements
- R1: After reset every readable register returns 0, the FIFO level reads 0, and `lrck_o`, `sdata_o` and `dma_req_o` are low.
- R2: Each write to address 0x24 pushes `bus_wdata` into the FIFO. Address 0x0C bits [5:0] read the occupancy. Writes made while 32 words are held are dropped.
- R3: `dma_req_o` is high exactly when address 0x10 bit 8 (request enable) is set and the occupancy is at or below the threshold in address 0x10 bits [4:0].
- R4: Address 0x38 bits [7:0] hold the bit period minus one, in block clocks, with a minimum of 1. `sclk_o` repeats with that period. `sdata_o` and `lrck_o` change only at bit boundaries, which are the falling edges of `sclk_o`.
- R5: Address 0x08 bits [7:0] hold the frame length in bits minus one. Slot 0 takes the first (length/2) bits with `lrck_o` high, and slot 1 takes the rest with `lrck_o` low. Each slot consumes one FIFO word.
- R6: Address 0x00 bits [4:0] hold the sample width minus one, and bits [10:9] select the placement. 01 starts the data at slot bit 0, 00 starts it at slot bit 1, and 10 ends it on the last slot bit. All other slot bits are 0.
- R7: Address 0x00 bit 11 set sends the sample LSB-first. Clear sends it MSB-first.
- R8: Writing 1 to address 0x1C bit 0 starts frames at the next bit boundary, beginning with slot 0. Writing 0 drives `sdata_o` and `lrck_o` low from the next bit boundary onward.
- R9: If the FIFO is empty when a slot begins while running, the previous word is sent again and address 0x0C bit 16 is set. The bit stays set until a clear.
- R10: Writing 1 to address 0x20 bit 0 makes that bit read 1 for one cycle. It empties the FIFO, clears the underflow flag and restarts the frame, while the control fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the master clock of the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Write address |
| bus_wdata | input | 32 | Write data |
| bus_rd_addr | input | 8 | Read address |
| bus_rdata | output | 32 | Read data, combinational from `bus_rd_addr` |
| sclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Slot select, high during slot 0 |
| sdata_o | output | 1 | Serial data |
| dma_req_o | output | 1 | Transmit data request |

## Verification
A wrong bit position or slot counter shows up on `sdata_o` within one frame, as a sample that is misplaced or bit-reversed against the bench's own slot model. It also shows as a slot-select edge in the wrong place. A corrupted FIFO pointer or occupancy shows up at once on the level register and on `dma_req_o`, and within a slot as a wrong or repeated word. A clear that fails to reset the serial side is caught at the next register read and by the alignment of the first frame after the restart.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int WORD_W = 32;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] A_FMT    = 8'h00;
  localparam logic [REG_AW-1:0] A_CLKGEN = 8'h08;
  localparam logic [REG_AW-1:0] A_LEVEL  = 8'h0C;
  localparam logic [REG_AW-1:0] A_REQ    = 8'h10;
  localparam logic [REG_AW-1:0] A_RUN    = 8'h1C;
  localparam logic [REG_AW-1:0] A_CLR    = 8'h20;
  localparam logic [REG_AW-1:0] A_DATA   = 8'h24;
  localparam logic [REG_AW-1:0] A_DIV    = 8'h38;

  localparam int UNDER_BIT = 16;

  typedef enum logic [1:0] {
    PLACE_DELAYED = 2'b00,
    PLACE_FRONT   = 2'b01,
    PLACE_BACK    = 2'b10,
    PLACE_SPARE   = 2'b11
  } place_e;

  // Slot length in bits for a frame of frame_m1+1 bits (first slot).
  function automatic logic [7:0] slot_len_of(input logic [7:0] frame_m1);
    logic [8:0] full;
    full = {1'b0, frame_m1} + 9'd1;
    return full[8:1];
  endfunction

  // Value of the serial line at bit 'pos' of a slot carrying 'word'.
  function automatic logic slot_bit(input logic [WORD_W-1:0] word,
                                    input logic [7:0] pos,
                                    input logic [7:0] slot_len,
                                    input logic [4:0] width_m1,
                                    input logic [1:0] place,
                                    input logic lsb_first);
    logic [8:0] width, off, k;
    width = {4'd0, width_m1} + 9'd1;
    case (place)
      PLACE_FRONT: off = 9'd0;
      PLACE_BACK:  off = {1'b0, slot_len} - width;
      default:     off = 9'd1;
    endcase
    k = {1'b0, pos} - off;
    if (({1'b0, pos} < off) || (k >= width)) return 1'b0;
    return lsb_first ? word[k[4:0]] : word[5'(width - 9'd1 - k)];
  endfunction
endpackage

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/aud_tx_bclk.sv
module aud_tx_bclk (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic [7:0] div_m1,
  output logic       tick,
  output logic       sclk
);
  logic [7:0] cnt;
  logic [7:0] half;

  assign half = 8'(({1'b0, div_m1} + 9'd1) >> 1);
  assign tick = (cnt >= div_m1);
  assign sclk = (cnt >= half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 8'd1;
  end
endmodule

// File: rtl/aud_tx_shifter.sv
module aud_tx_shifter import aud_tx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic              tick,
  input  logic [7:0]        frame_m1,
  input  logic [4:0]        width_m1,
  input  logic [1:0]        place,
  input  logic              lsb_first,
  input  logic [WORD_W-1:0] fifo_word,
  input  logic              fifo_empty,
  output logic              pop,
  output logic              underrun,
  output logic              sdata,
  output logic              lrck
);
  logic [7:0]        pos, slot_len, pos_in_slot;
  logic [WORD_W-1:0] last, cur;
  logic              at_edge, load;

  assign slot_len    = slot_len_of(frame_m1);
  assign at_edge     = (pos == 8'd0) || (pos == slot_len);
  assign pos_in_slot = (pos >= slot_len) ? pos - slot_len : pos;
  assign cur         = (at_edge && !fifo_empty) ? fifo_word : last;
  assign load        = tick && run && !clear && at_edge;
  assign pop         = load && !fifo_empty;
  assign underrun    = load && fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0; last <= '0; sdata <= 1'b0; lrck <= 1'b0;
    end else if (clear) begin
      pos <= '0; last <= '0; sdata <= 1'b0; lrck <= 1'b0;
    end else if (tick) begin
      if (run) begin
        sdata <= slot_bit(cur, pos_in_slot, slot_len, width_m1, place, lsb_first);
        lrck  <= (pos < slot_len);
        pos   <= (pos >= frame_m1) ? 8'd0 : pos + 8'd1;
        if (at_edge) last <= cur;
      end else begin
        pos <= '0; sdata <= 1'b0; lrck <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aud_tx_top.sv
module aud_tx_top import aud_tx_pkg::*; #(
  parameter int FIFO_DEPTH = 32,
  parameter bit DIV_IN_CKR = 1'b0,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [REG_AW-1:0] bus_rd_addr,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic              sdata_o,
  output logic              dma_req_o
);
  logic [4:0] width_m1, wmark;
  logic [1:0] place;
  logic       lsb_first, dma_en, xfer_on, clr_busy, under_flag;
  logic [7:0] frame_m1, div_m1;

  // events brought out for the checker
  logic             fifo_push, fifo_pop, fifo_empty, bit_tick, underrun;
  logic [WORD_W-1:0] fifo_word;
  logic [CNT_W-1:0]  fifo_count;
  logic              unused_wbits;

  assign unused_wbits = ^{bus_wdata[31:24], bus_wdata[15:12]};
  assign fifo_push    = bus_wr && (bus_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_m1 <= '0; place <= '0; lsb_first <= 1'b0; frame_m1 <= '0;
      div_m1 <= '0; wmark <= '0; dma_en <= 1'b0; xfer_on <= 1'b0;
      clr_busy <= 1'b0;
    end else begin
      clr_busy <= bus_wr && (bus_addr == A_CLR) && bus_wdata[0];
      if (bus_wr) begin
        case (bus_addr)
          A_FMT: begin
            width_m1  <= bus_wdata[4:0];
            place     <= bus_wdata[10:9];
            lsb_first <= bus_wdata[11];
          end
          A_CLKGEN: begin
            frame_m1 <= bus_wdata[7:0];
            if (DIV_IN_CKR) div_m1 <= bus_wdata[23:16];
          end
          A_DIV: if (!DIV_IN_CKR) div_m1 <= bus_wdata[7:0];
          A_REQ: begin
            wmark  <= bus_wdata[4:0];
            dma_en <= bus_wdata[8];
          end
          A_RUN:   xfer_on <= bus_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        under_flag <= 1'b0;
    else if (clr_busy) under_flag <= 1'b0;
    else if (underrun) under_flag <= 1'b1;
  end

  assign dma_req_o = dma_en && (32'(fifo_count) <= 32'(wmark));

  always_comb begin
    bus_rdata = '0;
    case (bus_rd_addr)
      A_FMT:    bus_rdata = {20'd0, lsb_first, place, 4'd0, width_m1};
      A_CLKGEN: bus_rdata = {8'd0, (DIV_IN_CKR ? div_m1 : 8'd0), 8'd0, frame_m1};
      A_LEVEL: begin
        bus_rdata[CNT_W-1:0] = fifo_count;
        bus_rdata[UNDER_BIT] = under_flag;
      end
      A_REQ:    bus_rdata = {23'd0, dma_en, 3'd0, wmark};
      A_RUN:    bus_rdata = {31'd0, xfer_on};
      A_CLR:    bus_rdata = {31'd0, clr_busy};
      A_DIV:    bus_rdata = {24'd0, (DIV_IN_CKR ? 8'd0 : div_m1)};
      default:  bus_rdata = '0;
    endcase
  end

  aud_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(clr_busy), .push(fifo_push),
    .din(bus_wdata), .pop(fifo_pop), .dout(fifo_word),
    .count(fifo_count), .empty(fifo_empty)
  );

  aud_tx_bclk u_bclk (
    .clk(clk), .rst_n(rst_n), .clear(clr_busy), .div_m1(div_m1),
    .tick(bit_tick), .sclk(sclk_o)
  );

  aud_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clear(clr_busy), .run(xfer_on), .tick(bit_tick),
    .frame_m1(frame_m1), .width_m1(width_m1), .place(place), .lsb_first(lsb_first),
    .fifo_word(fifo_word), .fifo_empty(fifo_empty), .pop(fifo_pop),
    .underrun(underrun), .sdata(sdata_o), .lrck(lrck_o)
  );
endmodule

// File: rtl/aud_tx_checks.sv
module aud_tx_checks #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH) + 1
)(
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          lrck,
  input logic          sdata,
  input logic          xfer,
  input logic          clr_busy,
  input logic          under,
  input logic [CW-1:0] count,
  input logic          dma_req,
  input logic          dma_en,
  input logic [4:0]    wmark
);
  // R2: occupancy never exceeds the FIFO depth
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);

  // R3: no request while disabled
  p_req_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req);

  // R3: no request above the threshold
  p_req_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(count) > 32'(wmark)) |-> !dma_req);

  // R4: serial outputs hold between bit boundaries
  p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_busy) |=> ($stable(sdata) && $stable(lrck)));

  // R8: a stopped engine goes quiet at the next boundary
  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !xfer && !clr_busy) |=> (!sdata && !lrck));

  // R9: the underflow flag is sticky until a clear
  p_under_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (under && !clr_busy) |=> under);

  // R10: a clear empties the FIFO and drops the flag
  p_clear_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> (count == '0 && !under));
endmodule

bind aud_tx_top aud_tx_checks #(.DEPTH(FIFO_DEPTH)) u_checks (
  .clk(clk), .rst_n(rst_n), .tick(bit_tick), .lrck(lrck_o), .sdata(sdata_o),
  .xfer(xfer_on), .clr_busy(clr_busy), .under(under_flag), .count(fifo_count),
  .dma_req(dma_req_o), .dma_en(dma_en), .wmark(wmark)
);

// File: tb/aud_tx_top_bench.sv
module aud_tx_top_bench;
  import aud_tx_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0, bus_rd_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sclk_o, lrck_o, sdata_o, dma_req_o;

  aud_tx_top u_aud_tx_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd_addr(bus_rd_addr), .bus_rdata(bus_rdata),
    .sclk_o(sclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o), .dma_req_o(dma_req_o)
  );

  int checks = 0, fails = 0;
  logic [1:0]  expq[$];
  logic [31:0] words[$];
  string cur_tag = "";
  bit mon_on = 0, synced = 0;
  logic sclk_prev = 1'b0, lrck_prev = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: samples mid-bit on each rising bit clock, compares with the queue
  always @(negedge clk) begin
    if (sclk_o && !sclk_prev) begin
      if (mon_on) begin
        if (!synced && lrck_o && !lrck_prev) synced = 1;
        if (synced && expq.size() > 0) begin
          logic [1:0] e;
          e = expq.pop_front();
          chk(cur_tag, {30'd0, lrck_o, sdata_o}, {30'd0, e});
        end
      end
      lrck_prev = lrck_o;
    end
    sclk_prev = sclk_o;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rreg(logic [7:0] a, output logic [31:0] d);
    bus_rd_addr = a;
    #1 d = bus_rdata;
  endtask

  // builds the expected line values slot by slot, then runs the engine
  task automatic ser_test(string tag, int w, int plc, bit lsb, int flen,
                          int nwords, int nframes);
    int slen;
    logic [31:0] last;
    wreg(A_CLR, 32'd1);
    idle(3);
    wreg(A_FMT, (32'(lsb) << 11) | (32'(plc) << 9) | 32'(w - 1));
    wreg(A_CLKGEN, 32'(flen));
    wreg(A_DIV, 32'd3);
    for (int i = 0; i < nwords; i++) wreg(A_DATA, words[i]);
    slen = (flen + 1) / 2;
    last = '0;
    for (int f = 0; f < nframes; f++) begin
      for (int s = 0; s < 2; s++) begin
        int len, st, idx;
        logic b;
        len = (s == 0) ? slen : flen + 1 - slen;
        st  = (plc == 1) ? 0 : ((plc == 2) ? slen - w : 1);
        idx = f * 2 + s;
        if (idx < nwords) last = words[idx];
        for (int p = 0; p < len; p++) begin
          b = 1'b0;
          if (p >= st && p < st + w) b = lsb ? last[p - st] : last[w - 1 - (p - st)];
          expq.push_back({(s == 0) ? 1'b1 : 1'b0, b});
        end
      end
    end
    cur_tag = tag;
    synced = 0;
    mon_on = 1;
    wreg(A_RUN, 32'd1);
    wait (expq.size() == 0);
    @(negedge clk);
    wreg(A_RUN, 32'd0);
    mon_on = 0;
    idle(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int per;
    words = '{32'hA5, 32'h3C, 32'hF0, 32'h81, 32'h5A, 32'hC3};
    idle(3);
    // R1 reset state
    chk("R1 lrck", {31'd0, lrck_o}, 0);
    chk("R1 sdata", {31'd0, sdata_o}, 0);
    chk("R1 dma_req", {31'd0, dma_req_o}, 0);
    rst_n = 1'b1;
    idle(2);
    rreg(A_FMT, d);   chk("R1 fmt", d, 0);
    rreg(A_LEVEL, d); chk("R1 level", d, 0);
    rreg(A_DIV, d);   chk("R1 div", d, 0);
    chk("R1 dma_req after reset", {31'd0, dma_req_o}, 0);

    // R2 occupancy and full drop
    for (int i = 0; i < 3; i++) wreg(A_DATA, 32'(i));
    rreg(A_LEVEL, d); chk("R2 level 3", d, 3);
    for (int i = 0; i < 31; i++) wreg(A_DATA, 32'(i));
    rreg(A_LEVEL, d); chk("R2 level full", d, 32);
    wreg(A_CLR, 32'd1); idle(2);

    // R3 request threshold
    wreg(A_REQ, 32'h102);
    chk("R3 req at 0", {31'd0, dma_req_o}, 1);
    wreg(A_DATA, 1); wreg(A_DATA, 2);
    chk("R3 req at threshold", {31'd0, dma_req_o}, 1);
    wreg(A_DATA, 3);
    chk("R3 req above", {31'd0, dma_req_o}, 0);
    wreg(A_REQ, 32'h01F);
    chk("R3 req disabled", {31'd0, dma_req_o}, 0);
    wreg(A_REQ, 32'h0);
    wreg(A_CLR, 32'd1); idle(2);

    // R4 bit period
    wreg(A_DIV, 32'd5);
    while (!(sclk_o && !sclk_prev)) @(negedge clk);
    @(negedge clk);
    per = 1;
    while (!(sclk_o && !sclk_prev)) begin @(negedge clk); per++; end
    chk("R4 period div5", 32'(per), 6);

    // R5/R6/R7/R8 serial formats
    ser_test("R6 front msb", 8, 1, 0, 15, 4, 2);
    ser_test("R7 front lsb", 8, 1, 1, 15, 4, 2);
    ser_test("R6 back width6", 6, 2, 0, 15, 4, 2);
    ser_test("R6 delayed width6", 6, 0, 0, 15, 4, 2);
    ser_test("R5 frame 24", 8, 1, 0, 23, 6, 3);

    // R8 stopped engine is quiet
    for (int i = 0; i < 6; i++) begin
      idle(3);
      chk("R8 quiet", {30'd0, lrck_o, sdata_o}, 0);
    end

    // R9 underflow repeats the word and sets the flag
    ser_test("R9 repeat", 8, 1, 0, 15, 1, 2);
    rreg(A_LEVEL, d); chk("R9 flag", d, 32'h1_0000);

    // R10 clear
    wreg(A_DATA, 7); wreg(A_DATA, 8);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 1;
    @(negedge clk);
    bus_wr = 1'b0;
    rreg(A_CLR, d); chk("R10 busy", d, 1);
    @(negedge clk);
    rreg(A_CLR, d); chk("R10 self clear", d, 0);
    rreg(A_LEVEL, d); chk("R10 level and flag", d, 0);
    rreg(A_FMT, d); chk("R10 fmt kept", d, 32'd7 | (32'd1 << 9));
    ser_test("R10 restart", 8, 1, 0, 15, 2, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule